// File: doc/BRIEF.md
# NAND Page DMA Engine

This block is a bus master that moves one flash page between a NAND interface and system memory. A page has two parts, the main data area and the spare area, and each part has its own memory address and its own enables. Software sets up the addresses, the spare-area length, the area enables and the ECC/EDC enables. It then writes a control word that gives the direction, the allowed burst sizes, the address cycle count and the chip select, and that starts the engine.

Once started, the engine sends the opening page command and then, depending on the direction, runs the data phase and the closing command. For a read it sends the command pair, waits for the flash to report ready, and then writes the page into memory. For a program it reads the page from memory, sends the closing command, and waits for the flash to report ready. Memory traffic is split into bursts. The data area goes first and the spare area follows. When the page is complete, the start bit drops and a DMA-done status bit is set, both on the same clock edge. ECC corrected and uncorrectable events from the neighbouring ECC logic set their own status bits. Every status bit can be masked onto the single interrupt line and is cleared by writing one to it.

Top module: `nand_page_dma`

## Requirements
- R1: Writing register 0 with bit0 set while idle starts a page transfer. Bit0 of register 0 reads 1 until the transfer ends. While it reads 1, writes to registers 0 to 4 are ignored: their readback, nf_cs_o and nf_addr_cyc_o stay unchanged, and no second transfer starts.
- R2: When control bit1 is 0 (read), the engine sends command 0x00 and then 0x30 on nf_cmd_o. It waits until nf_rb_i is 1. Only then does it issue memory bursts, each with mem_we_o = 1.
- R3: When control bit1 is 1 (program), the engine sends command 0x80, then issues memory bursts with mem_we_o = 0, then sends 0x10, and finishes only after nf_rb_i is 1. A command stays on nf_cmd_o with nf_cmd_valid_o high until nf_cmd_ready_i is seen.
- R4: The data area (PAGE_BYTES bytes, starting at register 1) is moved first. The spare area (register 3 bits [27:16] bytes, starting at register 2) is moved after it. The data area moves only when control bit2 and parameter bit0 are both set. The spare area moves only when control bit3 and parameter bit1 are both set and its length is non-zero.
- R5: Every burst length equals the smaller of the remaining bytes in the area and the largest allowed size. The allowed sizes are 16 if control bit6 is set, else 8 if bit5 is set, else 4 if bit4 is set, else 1. Successive burst addresses advance by the previous length. A request holds its address and length until mem_ack_i.
- R6: During a transfer, nf_cs_o equals control bits [9:8]. nf_addr_cyc_o is 4 when control bit7 is set and 5 when it is clear.
- R7: On the same clock edge where bit0 of register 0 falls, interrupt status bit9 (DMA done) is set.
- R8: An ecc_ce_i pulse sets status bit5 and an ecc_ue_i pulse sets status bit6. All status bits set whether or not they are enabled.
- R9: Writing register 7 clears each status bit that is written as one and leaves the others. If a set event and a clear of the same bit happen in the same cycle, the set wins.
- R10: irq_o is 1 exactly when some status bit among 9, 6 and 5 is set and its enable bit in register 5 is set.
- R11: ecc_en_o equals parameter register bits [5:2] (data EDC, spare EDC, data ECC, spare ECC).
- R12: Register map by word index: 0 control (bits [9:0]), 1 data address, 2 spare address, 3 length (bits [27:16]), 4 parameters (bits [5:0]), 5 interrupt enable, 6 interrupt status, 7 interrupt clear (reads 0). Bits outside these fields, and enable bits other than 9, 6 and 5, read 0. Every register reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| nf_cmd_valid_o | output | 1 | Flash command byte valid |
| nf_cmd_o | output | 8 | Flash command byte |
| nf_cmd_ready_i | input | 1 | Flash side accepts the command |
| nf_rb_i | input | 1 | Flash ready (1) or busy (0) |
| nf_cs_o | output | 2 | Selected flash chip |
| nf_addr_cyc_o | output | 3 | Address cycle count, 4 or 5 |
| mem_req_o | output | 1 | Memory burst request |
| mem_we_o | output | 1 | 1 writes memory, 0 reads memory |
| mem_addr_o | output | AW | Burst start byte address |
| mem_len_o | output | 5 | Burst length in bytes, 1 to 16 |
| mem_ack_i | input | 1 | Burst completed |
| ecc_ce_i | input | 1 | Corrected ECC error event |
| ecc_ue_i | input | 1 | Uncorrectable ECC error event |
| ecc_en_o | output | 4 | EDC/ECC enables for the ECC logic |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest condition to reach from the ports is a collision: a clear of a status bit arriving in the same cycle as a new event for that bit, or a control write landing while a page is in flight. The bench reaches both by driving the register strobe and the ECC event in the same cycle, and by writing inverted values to the control and address registers a few cycles after a start. It then reads them back while memory bursts are still running. Randomly timed acknowledges from the memory and flash models stretch each phase, and every burst is compared against a cursor that the bench keeps on its own.

// File: rtl/nfdma_pkg.sv
package nfdma_pkg;
  typedef enum logic [2:0] {
    RG_CTRL  = 3'd0,
    RG_DADDR = 3'd1,
    RG_OADDR = 3'd2,
    RG_LEN   = 3'd3,
    RG_PARA  = 3'd4,
    RG_IEN   = 3'd5,
    RG_ISTAT = 3'd6,
    RG_ICLR  = 3'd7
  } reg_idx_e;

  // control bits [9:1]
  typedef struct packed {
    logic [1:0] cs;
    logic       ac4;
    logic       b16;
    logic       b8;
    logic       b4;
    logic       oob_en;
    logic       data_en;
    logic       we;
  } ctrl_t;

  localparam int IB_CE  = 5;
  localparam int IB_UE  = 6;
  localparam int IB_DMA = 9;
  localparam logic [31:0] IRQ_MASK = (32'd1 << IB_DMA) | (32'd1 << IB_UE) | (32'd1 << IB_CE);

  localparam int LEN_LSB = 16;
  localparam int LEN_W   = 12;

  localparam logic [7:0] CMD_RD1 = 8'h00;
  localparam logic [7:0] CMD_RD2 = 8'h30;
  localparam logic [7:0] CMD_PG1 = 8'h80;
  localparam logic [7:0] CMD_PG2 = 8'h10;

  localparam int BLEN_W = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD1, S_CMD2, S_WAIT, S_DATA, S_OOB, S_DONE
  } state_e;
endpackage

// File: rtl/nfdma_regs.sv
module nfdma_regs
  import nfdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              ecc_ce_i,
  input  logic              ecc_ue_i,
  output logic              start_o,
  output ctrl_t             ctrl_o,
  output logic [AW-1:0]     daddr_o,
  output logic [AW-1:0]     oaddr_o,
  output logic [LEN_W-1:0]  olen_o,
  output logic [5:0]        para_o,
  output logic              irq_o
);
  ctrl_t             ctrl_q;
  logic [AW-1:0]     daddr_q, oaddr_q;
  logic [LEN_W-1:0]  olen_q;
  logic [5:0]        para_q;
  logic [31:0]       ien_q, stat_q, stat_set, stat_clr;
  logic              cfg_wr;

  assign cfg_wr  = reg_wr_i && !busy_i;
  assign start_o = cfg_wr && reg_addr_i == RG_CTRL && reg_wdata_i[0];

  always_comb begin
    stat_set = '0;
    stat_set[IB_DMA] = done_i;
    stat_set[IB_UE]  = ecc_ue_i;
    stat_set[IB_CE]  = ecc_ce_i;
    stat_clr = (reg_wr_i && reg_addr_i == RG_ICLR) ? (reg_wdata_i & IRQ_MASK) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      daddr_q <= '0;
      oaddr_q <= '0;
      olen_q  <= '0;
      para_q  <= '0;
      ien_q   <= '0;
      stat_q  <= '0;
    end else begin
      if (cfg_wr) begin
        case (reg_addr_i)
          RG_CTRL:  ctrl_q  <= ctrl_t'(reg_wdata_i[9:1]);
          RG_DADDR: daddr_q <= reg_wdata_i[AW-1:0];
          RG_OADDR: oaddr_q <= reg_wdata_i[AW-1:0];
          RG_LEN:   olen_q  <= reg_wdata_i[LEN_LSB +: LEN_W];
          RG_PARA:  para_q  <= reg_wdata_i[5:0];
          default: ;
        endcase
      end
      if (reg_wr_i && reg_addr_i == RG_IEN) ien_q <= reg_wdata_i & IRQ_MASK;
      stat_q <= (stat_q & ~stat_clr) | stat_set;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RG_CTRL:  reg_rdata_o[9:0] = {ctrl_q, busy_i};
      RG_DADDR: reg_rdata_o[AW-1:0] = daddr_q;
      RG_OADDR: reg_rdata_o[AW-1:0] = oaddr_q;
      RG_LEN:   reg_rdata_o[LEN_LSB +: LEN_W] = olen_q;
      RG_PARA:  reg_rdata_o[5:0] = para_q;
      RG_IEN:   reg_rdata_o = ien_q;
      RG_ISTAT: reg_rdata_o = stat_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign daddr_o = daddr_q;
  assign oaddr_o = oaddr_q;
  assign olen_o  = olen_q;
  assign para_o  = para_q;
  assign irq_o   = |(stat_q & ien_q);

  a_r7_done_sets_dma: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> stat_q[IB_DMA]);
  a_r9_set_wins_ue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_ue_i |=> stat_q[IB_UE]);
  a_r9_w1c_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == RG_ICLR && reg_wdata_i[IB_CE] && !ecc_ce_i) |=> !stat_q[IB_CE]);
  a_r1_ctrl_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && reg_wr_i) |=> ($stable(ctrl_q) && $stable(daddr_q) && $stable(olen_q)));
endmodule

// File: rtl/nfdma_burst.sv
module nfdma_burst
  import nfdma_pkg::*;
#(
  parameter int LW = 12
) (
  input  ctrl_t              ctrl_i,
  input  logic [LW-1:0]      rem_i,
  output logic [BLEN_W-1:0]  blen_o
);
  logic [BLEN_W-1:0] cap;

  always_comb begin
    if (ctrl_i.b16)     cap = BLEN_W'(16);
    else if (ctrl_i.b8) cap = BLEN_W'(8);
    else if (ctrl_i.b4) cap = BLEN_W'(4);
    else                cap = BLEN_W'(1);
    blen_o = (rem_i < LW'(cap)) ? BLEN_W'(rem_i) : cap;
  end
endmodule

// File: rtl/nfdma_seq.sv
module nfdma_seq
  import nfdma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int PAGE_BYTES = 2048,
  parameter int LW         = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  ctrl_t              ctrl_i,
  input  logic [AW-1:0]      daddr_i,
  input  logic [AW-1:0]      oaddr_i,
  input  logic [LEN_W-1:0]   olen_i,
  input  logic [5:0]         para_i,
  output logic               nf_cmd_valid_o,
  output logic [7:0]         nf_cmd_o,
  input  logic               nf_cmd_ready_i,
  input  logic               nf_rb_i,
  output logic [1:0]         nf_cs_o,
  output logic [2:0]         nf_addr_cyc_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [BLEN_W-1:0]  mem_len_o,
  input  logic               mem_ack_i,
  output logic               busy_o,
  output logic               done_o
);
  state_e        state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] rem_q, rem_d;
  logic [BLEN_W-1:0] blen;
  logic          want_data, want_oob, last_burst;

  // after-areas, spare-area and first-area targets
  state_e        post_st, oob_st, ent_st;
  logic [AW-1:0] oob_addr, ent_addr;
  logic [LW-1:0] oob_rem, ent_rem;

  nfdma_burst #(.LW(LW)) u_burst (
    .ctrl_i (ctrl_i),
    .rem_i  (rem_q),
    .blen_o (blen)
  );

  assign want_data  = ctrl_i.data_en && para_i[0];
  assign want_oob   = ctrl_i.oob_en && para_i[1] && (olen_i != '0);
  assign last_burst = rem_q == LW'(blen);

  always_comb begin
    post_st = ctrl_i.we ? S_CMD2 : S_DONE;
    if (want_oob) begin
      oob_st = S_OOB; oob_addr = oaddr_i; oob_rem = LW'(olen_i);
    end else begin
      oob_st = post_st; oob_addr = addr_q; oob_rem = rem_q;
    end
    if (want_data) begin
      ent_st = S_DATA; ent_addr = daddr_i; ent_rem = LW'(PAGE_BYTES);
    end else begin
      ent_st = oob_st; ent_addr = oob_addr; ent_rem = oob_rem;
    end
  end

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    case (state_q)
      S_IDLE: if (start_i) state_d = S_CMD1;
      S_CMD1: if (nf_cmd_ready_i) begin
        if (ctrl_i.we) begin
          state_d = ent_st; addr_d = ent_addr; rem_d = ent_rem;
        end else begin
          state_d = S_CMD2;
        end
      end
      S_CMD2: if (nf_cmd_ready_i) state_d = S_WAIT;
      S_WAIT: if (nf_rb_i) begin
        if (ctrl_i.we) begin
          state_d = S_DONE;
        end else begin
          state_d = ent_st; addr_d = ent_addr; rem_d = ent_rem;
        end
      end
      S_DATA: if (mem_ack_i) begin
        if (last_burst) begin
          state_d = oob_st; addr_d = oob_addr; rem_d = oob_rem;
        end else begin
          addr_d = addr_q + AW'(blen); rem_d = rem_q - LW'(blen);
        end
      end
      S_OOB: if (mem_ack_i) begin
        if (last_burst) begin
          state_d = post_st;
        end else begin
          addr_d = addr_q + AW'(blen); rem_d = rem_q - LW'(blen);
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
    end
  end

  always_comb begin
    nf_cmd_valid_o = (state_q == S_CMD1) || (state_q == S_CMD2);
    if (state_q == S_CMD1) nf_cmd_o = ctrl_i.we ? CMD_PG1 : CMD_RD1;
    else                   nf_cmd_o = ctrl_i.we ? CMD_PG2 : CMD_RD2;
  end

  assign nf_cs_o       = ctrl_i.cs;
  assign nf_addr_cyc_o = ctrl_i.ac4 ? 3'd4 : 3'd5;
  assign mem_req_o     = (state_q == S_DATA) || (state_q == S_OOB);
  assign mem_we_o      = !ctrl_i.we;
  assign mem_addr_o    = addr_q;
  assign mem_len_o     = blen;
  assign busy_o        = state_q != S_IDLE;
  assign done_o        = state_q == S_DONE;

  a_r5_burst_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_len_o != '0 && LW'(mem_len_o) <= rem_q &&
                   mem_len_o <= (ctrl_i.b16 ? 5'd16 : ctrl_i.b8 ? 5'd8 : ctrl_i.b4 ? 5'd4 : 5'd1)));
  a_r5_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_len_o)));
  a_r3_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nf_cmd_valid_o && !nf_cmd_ready_i) |=> (nf_cmd_valid_o && $stable(nf_cmd_o)));
  a_r6_cs_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(nf_cs_o) && $stable(nf_addr_cyc_o)));
  a_r7_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  a_r2_no_req_before_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !nf_cmd_valid_o);
endmodule

// File: rtl/nand_page_dma.sv
module nand_page_dma
  import nfdma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int PAGE_BYTES = 2048
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          nf_cmd_valid_o,
  output logic [7:0]    nf_cmd_o,
  input  logic          nf_cmd_ready_i,
  input  logic          nf_rb_i,
  output logic [1:0]    nf_cs_o,
  output logic [2:0]    nf_addr_cyc_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [4:0]    mem_len_o,
  input  logic          mem_ack_i,
  input  logic          ecc_ce_i,
  input  logic          ecc_ue_i,
  output logic [3:0]    ecc_en_o,
  output logic          irq_o
);
  localparam int MAXLEN = (PAGE_BYTES > 4095) ? PAGE_BYTES : 4095;
  localparam int LW     = $clog2(MAXLEN + 1);

  ctrl_t             ctrl;
  logic [AW-1:0]     daddr, oaddr;
  logic [LEN_W-1:0]  olen;
  logic [5:0]        para;
  logic              start, busy, done;

  nfdma_regs #(.AW(AW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .busy_i      (busy),
    .done_i      (done),
    .ecc_ce_i    (ecc_ce_i),
    .ecc_ue_i    (ecc_ue_i),
    .start_o     (start),
    .ctrl_o      (ctrl),
    .daddr_o     (daddr),
    .oaddr_o     (oaddr),
    .olen_o      (olen),
    .para_o      (para),
    .irq_o       (irq_o)
  );

  nfdma_seq #(.AW(AW), .PAGE_BYTES(PAGE_BYTES), .LW(LW)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start),
    .ctrl_i         (ctrl),
    .daddr_i        (daddr),
    .oaddr_i        (oaddr),
    .olen_i         (olen),
    .para_i         (para),
    .nf_cmd_valid_o (nf_cmd_valid_o),
    .nf_cmd_o       (nf_cmd_o),
    .nf_cmd_ready_i (nf_cmd_ready_i),
    .nf_rb_i        (nf_rb_i),
    .nf_cs_o        (nf_cs_o),
    .nf_addr_cyc_o  (nf_addr_cyc_o),
    .mem_req_o      (mem_req_o),
    .mem_we_o       (mem_we_o),
    .mem_addr_o     (mem_addr_o),
    .mem_len_o      (mem_len_o),
    .mem_ack_i      (mem_ack_i),
    .busy_o         (busy),
    .done_o         (done)
  );

  assign ecc_en_o = para[5:2];

  a_r11_ecc_en_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> $stable(ecc_en_o));
endmodule

// File: tb/tb_nand_page_dma.sv
`timescale 1ns/1ps
module tb_nand_page_dma;
  localparam int PAGE = 2048;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        nf_cmd_valid, nf_cmd_ready = 0, nf_rb = 1;
  logic [7:0]  nf_cmd;
  logic [1:0]  nf_cs;
  logic [2:0]  nf_addr_cyc;
  logic        mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr;
  logic [4:0]  mem_len;
  logic        ecc_ce = 0, ecc_ue = 0;
  logic [3:0]  ecc_en;
  logic        irq;

  nand_page_dma dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .nf_cmd_valid_o(nf_cmd_valid), .nf_cmd_o(nf_cmd), .nf_cmd_ready_i(nf_cmd_ready),
    .nf_rb_i(nf_rb), .nf_cs_o(nf_cs), .nf_addr_cyc_o(nf_addr_cyc),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_len_o(mem_len),
    .mem_ack_i(mem_ack), .ecc_ce_i(ecc_ce), .ecc_ue_i(ecc_ue), .ecc_en_o(ecc_en), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // bench-side cursor of expected bursts
  int          e_drem, e_orem, e_cap, x_err, ncmd;
  logic [31:0] e_daddr, e_oaddr;
  logic        e_we;
  logic [7:0]  cmds [4];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic int cap_of(input logic [9:0] c);
    if (c[6]) return 16;
    if (c[5]) return 8;
    if (c[4]) return 4;
    return 1;
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // memory model: random acknowledge, each burst compared with the cursor
  initial begin
    forever begin
      @(negedge clk);
      mem_ack = 0;
      if (mem_req && $urandom_range(0, 2) != 0) begin
        int el;
        if (mem_we !== !e_we || !nf_rb || ncmd != (e_we ? 1 : 2)) x_err++;
        if (e_drem > 0) begin
          el = imin(e_cap, e_drem);
          if (mem_addr !== e_daddr || int'(mem_len) != el) begin
            x_err++;
            $display("burst mismatch data addr %h len %0d exp %h %0d", mem_addr, mem_len, e_daddr, el);
          end
          e_daddr += el; e_drem -= el;
        end else if (e_orem > 0) begin
          el = imin(e_cap, e_orem);
          if (mem_addr !== e_oaddr || int'(mem_len) != el) begin
            x_err++;
            $display("burst mismatch spare addr %h len %0d exp %h %0d", mem_addr, mem_len, e_oaddr, el);
          end
          e_oaddr += el; e_orem -= el;
        end else begin
          x_err++;
          $display("unexpected burst at %h", mem_addr);
        end
        mem_ack = 1;
      end
    end
  end

  // flash model: random command accept, busy window after closing command
  initial begin
    int rb_cnt = 0;
    forever begin
      @(negedge clk);
      nf_cmd_ready = 0;
      if (rb_cnt > 0) begin
        rb_cnt--;
        if (rb_cnt == 0) nf_rb = 1;
      end
      if (nf_cmd_valid && $urandom_range(0, 1) == 1) begin
        if (ncmd < 4) cmds[ncmd] = nf_cmd;
        ncmd++;
        nf_cmd_ready = 1;
        if (nf_cmd == 8'h30 || nf_cmd == 8'h10) begin
          nf_rb = 0;
          rb_cnt = $urandom_range(2, 6);
        end
      end
    end
  end

  task automatic run_xfer(input logic [9:0] c, input logic [31:0] da, input logic [31:0] oa,
                          input int olen, input logic [5:0] para, input bit mid);
    logic [31:0] v;
    bit wd, wo, prev_busy, prev_irq, fell;
    wd = c[2] && para[0];
    wo = c[3] && para[1] && olen != 0;
    wr(3'd1, da);
    wr(3'd2, oa);
    wr(3'd3, 32'(olen) << 16);
    wr(3'd4, {26'd0, para});
    e_we = c[1]; e_cap = cap_of(c);
    e_drem = wd ? PAGE : 0; e_daddr = da;
    e_orem = wo ? olen : 0; e_oaddr = oa;
    x_err = 0; ncmd = 0;
    wr(3'd0, {22'd0, c[9:1], 1'b1});
    if (mid) begin
      repeat (3) @(negedge clk);
      wr(3'd0, {22'd0, ~c[9:1], 1'b1});
      wr(3'd1, ~da);
      rd(3'd0, v);
      chk("R1", "ctrl readback while busy", v, {22'd0, c[9:1], 1'b1});
      rd(3'd1, v);
      chk("R1", "data address frozen while busy", v, da);
      chk("R6", "chip select", {30'd0, nf_cs}, {30'd0, c[9:8]});
      chk("R6", "address cycles", {29'd0, nf_addr_cyc}, c[7] ? 32'd4 : 32'd5);
    end
    reg_addr = 3'd0;
    prev_busy = 1; prev_irq = 0; fell = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      #1;
      if (!reg_rdata[0]) begin
        fell = prev_busy;
        break;
      end
      prev_busy = reg_rdata[0];
      prev_irq = irq;
    end
    chk("R1", "start bit cleared", {31'd0, fell}, 32'd1);
    chk("R7", "done status with start clear", {30'd0, prev_irq, irq}, 32'b01);
    chk("R2", "command count", 32'(ncmd), 32'd2);
    chk(c[1] ? "R3" : "R2", "command pair", {16'd0, cmds[0], cmds[1]},
        c[1] ? 32'h8010 : 32'h0030);
    chk("R4", "bytes left in cursor", 32'(e_drem + e_orem), 32'd0);
    chk("R5", "burst mismatches", 32'(x_err), 32'd0);
    rd(3'd6, v);
    chk("R7", "status after done", v, 32'h200);
    wr(3'd7, 32'h200);
    rd(3'd6, v);
    chk("R9", "status cleared", v, 32'd0);
    chk("R10", "irq low after clear", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R12 reset values
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R12", "reset value", v, 32'd0);
    end
    chk("R12", "reset outputs", {29'd0, irq, mem_req, nf_cmd_valid}, 32'd0);

    // R12 field masking
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, v);
    chk("R12", "length field", v, 32'h0FFF_0000);
    wr(3'd4, 32'hFFFF_FFEB);
    rd(3'd4, v);
    chk("R12", "parameter field", v, 32'h2B);
    chk("R11", "ecc enables", {28'd0, ecc_en}, 32'hA);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, v);
    chk("R12", "enable field", v, 32'h260);

    // R8 / R10 masked status, then unmasked
    wr(3'd5, 32'h200);
    @(negedge clk) ecc_ce = 1;
    @(negedge clk) ecc_ce = 0;
    rd(3'd6, v);
    chk("R8", "ce status while masked", v, 32'h20);
    chk("R10", "irq masked", {31'd0, irq}, 32'd0);
    wr(3'd5, 32'h260);
    chk("R10", "irq enabled", {31'd0, irq}, 32'd1);
    @(negedge clk) ecc_ue = 1;
    @(negedge clk) ecc_ue = 0;
    wr(3'd7, 32'h40);
    rd(3'd6, v);
    chk("R9", "only written bit cleared", v, 32'h20);
    // set wins over clear in one cycle
    @(negedge clk);
    reg_wr = 1; reg_addr = 3'd7; reg_wdata = 32'h60; ecc_ue = 1;
    @(negedge clk);
    reg_wr = 0; ecc_ue = 0;
    rd(3'd6, v);
    chk("R9", "set wins over clear", v, 32'h40);
    wr(3'd7, 32'h260);
    chk("R10", "irq after clear all", {31'd0, irq}, 32'd0);
    wr(3'd5, 32'h200);

    // directed transfers
    run_xfer(10'h2DC, 32'h1000_0000, 32'h2000_0000, 64, 6'h03, 1); // R2 read both, 16-beat
    run_xfer(10'h136, 32'h3000_0100, 32'h4000_0000, 20, 6'h3F, 1); // R3 program data only, 8-beat
    run_xfer(10'h008, 32'h0,         32'h5000_0003, 13, 6'h02, 0); // R4 spare only, single beats
    run_xfer(10'h01A, 32'h0,         32'h6000_0000, 6,  6'h03, 0); // R5 program spare, 4 then 2
    run_xfer(10'h04C, 32'h7000_0000, 32'h7100_0000, 9,  6'h00, 0); // R4 both areas gated by params
    run_xfer(10'h04E, 32'h7200_0000, 32'h7300_0000, 0,  6'h03, 1); // R4 zero spare length skipped

    // random transfers
    for (int t = 0; t < 12; t++) begin
      logic [9:0] c;
      logic [5:0] p;
      c = 10'($urandom) & 10'h3FE;
      c[4] = 1'b1;
      p = 6'($urandom);
      run_xfer(c, $urandom, $urandom, $urandom_range(0, 40), p, c[2] && p[0]);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule